// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This block sits beside an 8-bit CPU core and picks one of sixteen interrupt request lines to present to it. Source 0 is the power-fail warning. It always sits in a fixed top level and is never masked. Sources 1 to 15 are maskable. Each one is ANDed with its own enable bit and with one global enable. A per-source priority bit places it in either the high or the low of two lower levels. The block presents the winning source's identifier and vector address, together with a request line, all from registers.

The core acknowledges a presented request with `ack`. The block then records that level in an in-service stack. While a level is in service, only a pending request from a strictly higher level is presented. A same-level or lower-level request waits. The core's `reti` strobe pops the most recent level, so any request it was holding off becomes visible again. Request lines are level-sensitive. Clearing a request is up to the source and the core.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, `irq_out` is 0, `irq_id` is 0, `irq_vec` is 0 and `svc_level` is 0. This holds whatever the request inputs are.
- R2: Source 0 (power-fail) qualifies whenever `irq_req[0]` is 1. `glb_en`, `irq_en[0]` and `prio_hi[0]` have no effect on it. It is at level 3 and vectors to 0x0033.
- R3: A source i from 1 to 15 qualifies only when `irq_req[i]`, `irq_en[i]` and `glb_en` are all 1.
- R4: With `glb_en` at 0, no source from 1 to 15 is ever presented, whatever its individual enable is.
- R5: A qualified source i ≥ 1 is at level 2 when `prio_hi[i]` is 1 and at level 1 when it is 0. A higher level always wins over a lower one.
- R6: Among qualified sources at the same level, the lowest index wins.
- R7: The vector of source i ≥ 1 is 0x0003 + 8·s, where s = i−1 for i ≤ 6 and s = i for i ≥ 7, so slot 6 (0x0033) is left to power-fail. When `irq_out` is 0, `irq_id` and `irq_vec` are 0.
- R8: The outputs are registered. A change on the inputs appears on `irq_out`, `irq_id` and `irq_vec` one clock edge later and not before.
- R9: An `ack` while `irq_out` is 1 pushes the presented level. From the next cycle, `svc_level` (0 = none, 1 = low, 2 = high, 3 = power-fail) shows that level. An `ack` while `irq_out` is 0 is ignored.
- R10: A pending winner is presented only when its level is strictly greater than the current in-service level.
- R11: `reti` pops the current level, so `svc_level` returns to the level below it. `reti` with nothing in service is ignored. When `reti` and a valid `ack` fall in the same cycle, the pop is applied first and then the push.
- R12: Power-fail preempts a high-level service in progress, and can be acknowledged to reach `svc_level` 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 16 | Level request per source; bit 0 is power-fail |
| irq_en | input | 16 | Per-source enable; bit 0 unused |
| prio_hi | input | 16 | Per-source level select, 1 = high; bit 0 unused |
| glb_en | input | 1 | Global enable for sources 1 to 15 |
| ack | input | 1 | Core accepts the presented request |
| reti | input | 1 | Core returns from the current service |
| irq_out | output | 1 | Request to the core |
| irq_id | output | 4 | Index of the presented source |
| irq_vec | output | 16 | Vector address of the presented source |
| svc_level | output | 2 | Highest level in service |

## Verification
Every result is due exactly one rising edge after the inputs that cause it. This holds for the presented request, its identifier and vector, and the in-service level after `ack` or `reti`. The bench therefore changes inputs 1 ns after an edge. It predicts the next state from those inputs and its own model of the stack, then compares 1 ns after the following edge. For R8, the bench also checks that no output has moved when the inputs change but the next edge has not yet come. The sweeps cover every single source with the global enable both on and off, plus long pseudo-random runs of masks, levels, acknowledges and returns.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_TOP  = 2'd3
  } irq_lvl_e;
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int N_SRC = 16
) (
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] en,
  input  logic [N_SRC-1:0] phi,
  input  logic             glb,
  output logic             top_c,
  output logic [N_SRC-1:0] hi_c,
  output logic [N_SRC-1:0] lo_c
);
  logic unused_bits;
  assign unused_bits = ^{en[0], phi[0]};

  // power-fail line bypasses every mask
  assign top_c   = req[0];
  assign hi_c[0] = 1'b0;
  assign lo_c[0] = 1'b0;

  for (genvar i = 1; i < N_SRC; i++) begin : g_src
    logic q;
    assign q       = req[i] & en[i] & glb;
    assign hi_c[i] = q & phi[i];
    assign lo_c[i] = q & ~phi[i];
  end
endmodule

// File: rtl/irq_first.sv
module irq_first #(
  parameter int N_SRC = 16,
  parameter int IDW   = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] cand,
  output logic             found,
  output logic [IDW-1:0]   idx
);
  // scan downward so the lowest set index is the last one written
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = i[IDW-1:0];
      end
    end
  end
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack #(
  parameter int NLVL = 3,
  parameter int LW   = $clog2(NLVL + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [LW-1:0] push_lvl,
  input  logic          pop,
  output logic [LW-1:0] cur_d,
  output logic [LW-1:0] cur_q
);
  // one bit per level; levels only nest upward, so a mask is a stack
  logic [NLVL:1] mask_q;
  logic [NLVL:1] mask_d;

  always_comb begin
    logic hit;
    mask_d = mask_q;
    hit    = 1'b0;
    if (pop) begin
      for (int l = NLVL; l >= 1; l--) begin
        if (!hit && mask_d[l]) begin
          mask_d[l] = 1'b0;
          hit       = 1'b1;
        end
      end
    end
    if (push) begin
      for (int l = 1; l <= NLVL; l++) begin
        if (int'(push_lvl) == l) mask_d[l] = 1'b1;
      end
    end
  end

  always_comb begin
    cur_d = '0;
    for (int l = 1; l <= NLVL; l++) begin
      if (mask_d[l]) cur_d = l[LW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      cur_q  <= '0;
    end else begin
      mask_q <= mask_d;
      cur_q  <= cur_d;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC    = 16,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  parameter int PF_VEC   = 51,
  parameter int IDW      = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] irq_en,
  input  logic [N_SRC-1:0] prio_hi,
  input  logic             glb_en,
  input  logic             ack,
  input  logic             reti,
  output logic             irq_out,
  output logic [IDW-1:0]   irq_id,
  output logic [VEC_W-1:0] irq_vec,
  output logic [1:0]       svc_level
);
  localparam int PF_SLOT = (PF_VEC - VEC_BASE) / VEC_STEP;
  localparam int NGRP    = 2;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDW-1:0] id);
    int s;
    s = int'(id) - 1;
    if (s >= PF_SLOT) s = s + 1;
    return VEC_W'(VEC_BASE + VEC_STEP * s);
  endfunction

  logic             top_c;
  logic [N_SRC-1:0] hi_c, lo_c;
  logic [N_SRC-1:0] grp_cand [NGRP];
  logic             grp_found[NGRP];
  logic [IDW-1:0]   grp_idx  [NGRP];

  irq_qualify #(.N_SRC(N_SRC)) u_qual (
    .req  (irq_req),
    .en   (irq_en),
    .phi  (prio_hi),
    .glb  (glb_en),
    .top_c(top_c),
    .hi_c (hi_c),
    .lo_c (lo_c)
  );

  // index 0 = low level, index 1 = high level
  assign grp_cand[0] = lo_c;
  assign grp_cand[1] = hi_c;

  for (genvar g = 0; g < NGRP; g++) begin : g_lvl
    irq_first #(.N_SRC(N_SRC), .IDW(IDW)) u_first (
      .cand (grp_cand[g]),
      .found(grp_found[g]),
      .idx  (grp_idx[g])
    );
  end

  logic             out_q;
  logic [IDW-1:0]   id_q;
  logic [VEC_W-1:0] vec_q;
  logic [1:0]       lvl_q;
  logic [1:0]       cur_d, cur_q;

  irq_svc_stack #(.NLVL(3), .LW(2)) u_stack (
    .clk     (clk),
    .rst     (rst),
    .push    (ack & out_q),
    .push_lvl(lvl_q),
    .pop     (reti),
    .cur_d   (cur_d),
    .cur_q   (cur_q)
  );

  logic [1:0]     win_lvl;
  logic [IDW-1:0] win_id;
  logic           take;

  always_comb begin
    win_lvl = LVL_NONE;
    win_id  = '0;
    if (top_c) begin
      win_lvl = LVL_TOP;
    end else if (grp_found[1]) begin
      win_lvl = LVL_HIGH;
      win_id  = grp_idx[1];
    end else if (grp_found[0]) begin
      win_lvl = LVL_LOW;
      win_id  = grp_idx[0];
    end
  end

  // compared against the stack as it stands after this cycle's ack/reti
  assign take = (win_lvl > cur_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
      id_q  <= '0;
      vec_q <= '0;
      lvl_q <= '0;
    end else begin
      out_q <= take;
      id_q  <= take ? win_id : '0;
      lvl_q <= take ? win_lvl : 2'd0;
      if (!take)                   vec_q <= '0;
      else if (win_lvl == LVL_TOP) vec_q <= VEC_W'(PF_VEC);
      else                         vec_q <= vec_of(win_id);
    end
  end

  assign irq_out   = out_q;
  assign irq_id    = id_q;
  assign irq_vec   = vec_q;
  assign svc_level = cur_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int N_SRC = 16,
  parameter int VEC_W = 16,
  parameter int IDW   = $clog2(N_SRC)
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] irq_req,
  input logic             glb_en,
  input logic             ack,
  input logic             reti,
  input logic             irq_out,
  input logic [IDW-1:0]   irq_id,
  input logic [VEC_W-1:0] irq_vec,
  input logic [1:0]       svc_level,
  input logic [1:0]       out_lvl
);
  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_out && svc_level == 2'd0 && irq_vec == '0));

  p_pf_bypass_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(irq_req[0]) && $past(svc_level) != 2'd3
     && !$past(ack) && !$past(reti)) |-> (irq_out && irq_id == '0));

  p_mask_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(glb_en) && !$past(irq_req[0])) |-> !irq_out);

  p_pf_vector_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_out && irq_id == '0) |-> irq_vec == VEC_W'(51));

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !irq_out |-> (irq_id == '0 && irq_vec == '0));

  p_ack_push_r9: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_out && !reti) |=> svc_level == $past(out_lvl));

  p_strict_r10: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> out_lvl > svc_level);

  p_reti_pop_r11: assert property (@(posedge clk) disable iff (rst)
    (reti && !ack && svc_level != 2'd0) |=> svc_level < $past(svc_level));

  p_reti_empty_r11: assert property (@(posedge clk) disable iff (rst)
    (reti && !ack && svc_level == 2'd0) |=> svc_level == 2'd0);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W), .IDW(IDW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_req  (irq_req),
  .glb_en   (glb_en),
  .ack      (ack),
  .reti     (reti),
  .irq_out  (irq_out),
  .irq_id   (irq_id),
  .irq_vec  (irq_vec),
  .svc_level(svc_level),
  .out_lvl  (lvl_q)
);

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] req = '0, en = '0, phi = '0;
  logic        glb = 1'b0, ack = 1'b0, reti = 1'b0;
  logic        irq_out;
  logic [3:0]  irq_id;
  logic [15:0] irq_vec;
  logic [1:0]  svc_level;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // bench model state
  logic [3:1] m_stack = '0;
  logic       m_out = 1'b0;
  logic [3:0] m_id = '0;
  logic [1:0] m_lvl = '0;
  logic [31:0] seed = 32'h1234_5679;

  always #2.5 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst(rst), .irq_req(req), .irq_en(en), .prio_hi(phi),
    .glb_en(glb), .ack(ack), .reti(reti), .irq_out(irq_out),
    .irq_id(irq_id), .irq_vec(irq_vec), .svc_level(svc_level)
  );

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [15:0] vexp(input logic [3:0] id);
    int s;
    if (id == 0) return 16'h0033;
    s = int'(id) - 1;
    if (id >= 7) s = s + 1;
    return 16'(3 + 8 * s);
  endfunction

  function automatic logic [1:0] top_of(input logic [3:1] st);
    if (st[3]) return 2'd3;
    if (st[2]) return 2'd2;
    if (st[1]) return 2'd1;
    return 2'd0;
  endfunction

  task automatic check(input string tag, input logic eo, input logic [3:0] ei,
                       input logic [15:0] ev, input logic [1:0] es);
    tests++;
    if (irq_out !== eo || irq_id !== ei || irq_vec !== ev || svc_level !== es) begin
      fails++;
      $display("FAIL %s: out=%0b id=%0d vec=%h svc=%0d expected out=%0b id=%0d vec=%h svc=%0d",
               tag, irq_out, irq_id, irq_vec, svc_level, eo, ei, ev, es);
    end
  endtask

  // apply current inputs for one edge, predict and compare
  task automatic cycle(input string tag);
    logic [3:1] st;
    logic [1:0] cur, best;
    logic [3:0] bid;
    logic       q;
    logic [1:0] l;
    st = m_stack;
    if (reti && st != 0) begin
      if (st[3]) st[3] = 1'b0;
      else if (st[2]) st[2] = 1'b0;
      else st[1] = 1'b0;
    end
    if (ack && m_out) st[m_lvl] = 1'b1;
    cur  = top_of(st);
    best = 2'd0;
    bid  = 4'd0;
    for (int i = 0; i < 16; i++) begin
      q = (i == 0) ? req[0] : (req[i] & en[i] & glb);
      l = (i == 0) ? 2'd3 : (phi[i] ? 2'd2 : 2'd1);
      if (q && l > best) begin
        best = l;
        bid  = 4'(i);
      end
    end
    m_stack = st;
    m_out   = best > cur;
    m_id    = m_out ? bid : 4'd0;
    m_lvl   = m_out ? best : 2'd0;
    @(posedge clk);
    #1;
    check(tag, m_out, m_id, m_out ? vexp(m_id) : 16'h0, cur);
  endtask

  task automatic idle_inputs();
    req = '0; en = '0; phi = '0; glb = 1'b0; ack = 1'b0; reti = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req = 16'hFFFF; en = 16'hFFFF; glb = 1'b1; ack = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", 1'b0, 4'd0, 16'h0, 2'd0);
    idle_inputs();
    rst = 1'b0;
    m_stack = '0; m_out = 1'b0; m_id = '0; m_lvl = '0;
    cycle("R1 after release");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: out=%0b expected run to finish", irq_out);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1;
    do_reset();

    // R2 R3 R7: every single source, global on and off, own enable on and off
    for (int i = 0; i < 16; i++) begin
      for (int g = 0; g < 2; g++) begin
        idle_inputs();
        req = 16'(1) << i; en = 16'hFFFF; phi = (i % 2) ? 16'hFFFF : 16'h0;
        glb = g[0];
        cycle("R7 R2 single source vector");
        en = ~(16'(1) << i);
        cycle("R3 R2 own enable cleared");
      end
    end

    // R4: global enable off blocks all maskable sources
    idle_inputs();
    req = 16'hFFFE; en = 16'hFFFF; phi = 16'hAAAA; glb = 1'b0;
    cycle("R4 global off");
    req = 16'hFFFF;
    cycle("R4 only power-fail passes");
    req = '0;
    cycle("R4 idle");

    // R8: input change not visible before the edge
    req = 16'h0008; en = 16'hFFFF; glb = 1'b1;
    #1;
    check("R8 before edge", 1'b0, 4'd0, 16'h0, 2'd0);
    cycle("R8 after one edge");

    // R5 R6: pseudo-random masks and levels, empty stack
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a, b;
      a = rnd(); b = rnd();
      req = a[15:0] & {15'h7FFF, (a[16] & a[17])};
      en  = a[31:16] | b[15:0];
      phi = b[31:16];
      glb = (b[7:5] != 3'b000);
      cycle("R5 R6 random arbitration");
    end

    // directed service sequence: R9 R10 R11 R12
    idle_inputs();
    cycle("R9 setup");
    ack = 1'b1;
    cycle("R9 ack with no request ignored");
    ack = 1'b0; reti = 1'b1;
    cycle("R11 reti on empty ignored");
    reti = 1'b0;
    en = 16'hFFFF; glb = 1'b1; phi = 16'h0200;
    req = 16'h0020;
    cycle("R9 low source 5 presented");
    ack = 1'b1;
    cycle("R9 ack pushes low level");
    ack = 1'b0;
    req = 16'h0024;
    cycle("R10 same level source 2 held off");
    req = 16'h0224;
    cycle("R10 high source 9 preempts");
    ack = 1'b1;
    cycle("R9 ack pushes high level");
    ack = 1'b0; phi = 16'h0210;
    req = 16'h0234;
    cycle("R10 high source 4 held off");
    req = 16'h0235;
    cycle("R12 power-fail preempts high");
    ack = 1'b1;
    cycle("R12 ack reaches level 3");
    ack = 1'b0; req = 16'h0234;
    cycle("R10 nothing above level 3");
    reti = 1'b1;
    cycle("R11 pop to high");
    reti = 1'b0; req = 16'h0001;
    cycle("R11 power-fail again presented");
    reti = 1'b1; ack = 1'b1;
    cycle("R11 pop then push together");
    ack = 1'b0;
    cycle("R11 pop");
    cycle("R11 pop");
    cycle("R11 pop to empty");
    reti = 1'b0;

    // R9 R10 R11: random mixed service traffic
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, b;
      a = rnd(); b = rnd();
      req  = a[15:0] & {15'h7FFF, (a[16] & a[17] & a[18])};
      en   = a[31:16] | b[15:0];
      phi  = b[31:16];
      glb  = b[9] | b[10];
      ack  = b[2] & b[3];
      reti = b[4] & b[5] & b[6];
      cycle("R9 R10 R11 random service");
    end

    idle_inputs();
    do_reset();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule